// File: doc/BRIEF.md
# Port-Side Register Bank for a 16-Pin I/O Expander

This block holds the per-pin state of a two-port, eight-bits-per-port general-purpose I/O expander. A serial front end drives a byte-wide register access port: a register index, a write strobe with write data, and a read strobe that returns one byte on the following cycle. Each port has four byte registers: a live input view, a stored output value, an inversion mask applied to input reads, and a direction mask. The block drives the pin output values and per-pin output enables. It samples the pin levels through a two-flop synchronizer.

The interrupt watches every pin that is configured as an input. It compares the synchronized level with a per-port snapshot, which is taken at the moment that port's input register is read. A mismatch on either port pulls a registered open-drain enable high, which means the shared interrupt line is driven low. A port's pending condition goes away when its input register is read, or when its pins return to the snapshot value. Reading one port never clears the other port's condition.

Top module: `xpdr_port_regs`

## Requirements
- R1: The register index is {kind, port}: the low bit selects port 0 or port 1, and the upper two bits select the kind (0 input, 1 output value, 2 inversion mask, 3 direction). A read strobe loads `rd_data` at that clock edge, and `rd_data` holds until the next read strobe.
- R2: After reset, both output registers are 0xFF, both inversion masks are 0x00, both direction registers are 0xFF, both input snapshots are 0x00, `rd_data` is 0x00 and `irq_pull_en` is 0.
- R3: A direction bit of 1 makes the pin an input with `pin_oe` low. A direction bit of 0 sets `pin_oe` high and drives the pin from the matching output register bit on `pin_out`.
- R4: Writes to indexes 0 and 1 change no register, no pin output and no pin enable.
- R5: A read of index 2 or 3 returns the stored output byte, not the level on the pins.
- R6: A read of index 0 or 1 returns the synchronized pin byte XOR that port's inversion mask, whatever the pins' direction.
- R7: `irq_pull_en` goes to 1 when any input-configured pin differs from its port's snapshot. A pin whose direction bit is 0 never causes it.
- R8: A read of a port's input register loads that port's snapshot with the synchronized pin byte and clears that port's pending condition. The other port's pending condition is unaffected.
- R9: When every differing input pin returns to its snapshot value, the pending condition clears without any read.
- R10: Changing a pin from output to input while its level differs from the snapshot raises the interrupt. This is not suppressed.
- R11: A pin change sampled at clock edge k shows on `irq_pull_en` after edge k+2. The change passes two synchronizer stages and then the interrupt register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 3 | Register index {kind, port} |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe for the indexed register |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 16 | Pin levels, port 1 in bits 15:8 |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables, 1 = driven |
| irq_pull_en | output | 1 | 1 = pull the shared active-low interrupt line low |

## Verification
The hardest case is a port-crossed clear. Both ports must be pending at once, and then only one of them is read, so the interrupt must stay up for the correct reason. The bench first gives both snapshots a known value. It then moves pins on both ports away from that value and reads a single port's input register. It checks that the line stays pulled, and only then reads the second port. The output-to-input case is reached in a similar way. The bench sets pins to levels that the direction mask hides from the comparison, and then flips the direction bits back to input.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    K_IN  = 2'd0,
    K_OUT = 2'd1,
    K_INV = 2'd2,
    K_DIR = 2'd3
  } reg_kind_e;

  // Byte seen by a reader of the input register.
  function automatic logic [BYTE_W-1:0] in_view(input logic [BYTE_W-1:0] lvl,
                                                input logic [BYTE_W-1:0] inv);
    return lvl ^ inv;
  endfunction

  // Any input-configured bit disagreeing with the snapshot.
  function automatic logic any_pending(input logic [BYTE_W-1:0] lvl,
                                       input logic [BYTE_W-1:0] snap,
                                       input logic [BYTE_W-1:0] dir);
    return |((lvl ^ snap) & dir);
  endfunction

endpackage

// File: rtl/xpdr_sync.sv
module xpdr_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xpdr_port_slice.sv
module xpdr_port_slice
  import xpdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] lvl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_out,
  input  logic              wr_inv,
  input  logic              wr_dir,
  input  logic              snap_take,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] inv_q,
  output logic [BYTE_W-1:0] dir_q,
  output logic [BYTE_W-1:0] snap_q,
  output logic              pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      inv_q  <= '0;
      dir_q  <= '1;
      snap_q <= '0;
    end else begin
      if (wr_out)    out_q  <= wr_data;
      if (wr_inv)    inv_q  <= wr_data;
      if (wr_dir)    dir_q  <= wr_data;
      if (snap_take) snap_q <= lvl;
    end
  end

  assign pend = any_pending(lvl, snap_q, dir_q);
endmodule

// File: rtl/xpdr_port_regs.sv
module xpdr_port_regs
  import xpdr_pkg::*;
#(
  parameter int PORTS = 2,
  localparam int PSW  = $clog2(PORTS),
  localparam int IDXW = PSW + 2,
  localparam int NPIN = PORTS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDXW-1:0]   reg_idx,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq_pull_en
);
  reg_kind_e          sel_kind;
  logic [PSW-1:0]     sel_port;
  logic [NPIN-1:0]    pin_sync;
  logic [PORTS-1:0]   port_pend;
  logic [PORTS-1:0]   snap_take;
  logic [BYTE_W-1:0]  out_a  [PORTS];
  logic [BYTE_W-1:0]  inv_a  [PORTS];
  logic [BYTE_W-1:0]  dir_a  [PORTS];
  logic [BYTE_W-1:0]  snap_a [PORTS];
  logic [BYTE_W-1:0]  lvl_a  [PORTS];
  logic [BYTE_W-1:0]  rd_mux;

  assign sel_kind = reg_kind_e'(reg_idx[IDXW-1 -: 2]);
  assign sel_port = reg_idx[PSW-1:0];

  xpdr_sync #(.W(NPIN)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic hit;
    assign hit          = (sel_port == PSW'(p));
    assign lvl_a[p]     = pin_sync[p*BYTE_W +: BYTE_W];
    assign snap_take[p] = rd_en && hit && (sel_kind == K_IN);

    xpdr_port_slice slice_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_a[p]),
      .wr_data  (wr_data),
      .wr_out   (wr_en && hit && (sel_kind == K_OUT)),
      .wr_inv   (wr_en && hit && (sel_kind == K_INV)),
      .wr_dir   (wr_en && hit && (sel_kind == K_DIR)),
      .snap_take(snap_take[p]),
      .out_q    (out_a[p]),
      .inv_q    (inv_a[p]),
      .dir_q    (dir_a[p]),
      .snap_q   (snap_a[p]),
      .pend     (port_pend[p])
    );

    assign pin_out[p*BYTE_W +: BYTE_W] = out_a[p];
    assign pin_oe[p*BYTE_W +: BYTE_W]  = ~dir_a[p];
  end

  always_comb begin
    unique case (sel_kind)
      K_IN:    rd_mux = in_view(lvl_a[sel_port], inv_a[sel_port]);
      K_OUT:   rd_mux = out_a[sel_port];
      K_INV:   rd_mux = inv_a[sel_port];
      default: rd_mux = dir_a[sel_port];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      irq_pull_en <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      irq_pull_en <= |port_pend;
    end
  end
endmodule

// File: rtl/xpdr_port_regs_chk.sv
module xpdr_port_regs_chk
  import xpdr_pkg::*;
#(
  parameter int PORTS = 2,
  localparam int PSW  = $clog2(PORTS),
  localparam int IDXW = PSW + 2,
  localparam int NPIN = PORTS * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDXW-1:0]   reg_idx,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_data,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [PORTS-1:0]  port_pend,
  input logic [PORTS-1:0]  snap_take,
  input logic [NPIN-1:0]   pin_sync
);
  localparam logic [IDXW-1:0] IDX_OUT0 = IDXW'(1 << PSW);
  localparam logic [IDXW-1:0] IDX_DIR0 = IDXW'(3 << PSW);

  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IDX_DIR0) |=> pin_oe[BYTE_W-1:0] == ~$past(wr_data));

  p_in_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx[IDXW-1 -: 2] == 2'd0) |=> ($stable(pin_out) && $stable(pin_oe)));

  p_out_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IDX_OUT0) |=> pin_out[BYTE_W-1:0] == $past(wr_data));

  p_outputs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&pin_oe[BYTE_W-1:0]) |-> !port_pend[0]);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_take[0] ##1 (pin_sync[BYTE_W-1:0] == $past(pin_sync[BYTE_W-1:0])) |-> !port_pend[0]);
endmodule

bind xpdr_port_regs xpdr_port_regs_chk #(.PORTS(PORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
  .pin_out(pin_out), .pin_oe(pin_oe), .port_pend(port_pend),
  .snap_take(snap_take), .pin_sync(pin_sync)
);

// File: tb/xpdr_port_regs_tb_top.sv
module xpdr_port_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq_pull_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xpdr_port_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_pull_en(irq_pull_en)
  );

  task automatic expect_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] d);
    reg_idx = idx; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_expect(input string req, input logic [2:0] idx, input logic [7:0] exp);
    logic [7:0] v;
    rd(idx, v);
    expect_eq(req, {8'h00, v}, {8'h00, exp});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] inv, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    expect_eq("R2 pin_oe", pin_oe, 16'h0000);
    expect_eq("R2 pin_out", pin_out, 16'hFFFF);
    expect_eq("R2 irq", {15'd0, irq_pull_en}, 16'd0);
    expect_eq("R2 rd_data", {8'd0, rd_data}, 16'd0);
    rd_expect("R2 out0", 3'd2, 8'hFF);
    rd_expect("R2 out1", 3'd3, 8'hFF);
    rd_expect("R2 inv0", 3'd4, 8'h00);
    rd_expect("R2 inv1", 3'd5, 8'h00);
    rd_expect("R2 dir0", 3'd6, 8'hFF);
    rd_expect("R2 dir1", 3'd7, 8'hFF);

    // R1 R3 R5 register map and pin drive
    wr(3'd2, 8'hA5); wr(3'd3, 8'h3C); wr(3'd6, 8'h0F); wr(3'd7, 8'hF0);
    expect_eq("R3 pin_oe", pin_oe, 16'h0FF0);
    expect_eq("R3 pin_out", pin_out, 16'h3CA5);
    rd_expect("R5 out0 not pin", 3'd2, 8'hA5);
    rd_expect("R5 out1 not pin", 3'd3, 8'h3C);
    rd_expect("R1 dir0", 3'd6, 8'h0F);
    rd_expect("R1 dir1", 3'd7, 8'hF0);
    v = rd_data;
    wait_cyc(2);
    expect_eq("R1 rd_data holds", {8'd0, rd_data}, {8'd0, v});

    // R4 input-register writes ignored
    wr(3'd0, 8'h55); wr(3'd1, 8'hAA);
    expect_eq("R4 pin_out", pin_out, 16'h3CA5);
    expect_eq("R4 pin_oe", pin_oe, 16'h0FF0);
    rd_expect("R4 inv0", 3'd4, 8'h00);
    rd_expect("R4 inv1", 3'd5, 8'h00);
    rd_expect("R4 in0", 3'd0, 8'h00);

    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd0, v); rd(3'd1, v);
    wait_cyc(3);
    expect_eq("R7 idle irq", {15'd0, irq_pull_en}, 16'd0);

    // R6 sweep of levels and inversion masks on each port
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 16; k++) begin
        v   = 8'(k * 17);
        inv = 8'(k * 3) ^ 8'h5A;
        wr(3'(4 + p), inv);
        pin_in = (p == 0) ? {pin_in[15:8], v} : {v, pin_in[7:0]};
        wait_cyc(4);
        rd_expect("R6 input view", 3'(p), v ^ inv);
      end
    end
    wr(3'd6, 8'h00);
    pin_in[7:0] = 8'h81;
    wait_cyc(4);
    rd_expect("R6 view on output pin", 3'd0, 8'h81 ^ 8'h5A ^ 8'h2D);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'hFF);

    // R7 R9 walk a single bit across all pins
    pin_in = 16'h0000;
    wait_cyc(4);
    rd(3'd0, v); rd(3'd1, v);
    wait_cyc(2);
    for (int b = 0; b < 16; b++) begin
      pin_in[b] = 1'b1;
      wait_cyc(4);
      expect_eq("R7 bit raises irq", {15'd0, irq_pull_en}, 16'd1);
      pin_in[b] = 1'b0;
      wait_cyc(4);
      expect_eq("R9 return clears irq", {15'd0, irq_pull_en}, 16'd0);
    end

    // R7 output pins never interrupt; R10 direction flip raises it
    wr(3'd6, 8'h00); wr(3'd7, 8'h00);
    pin_in = 16'hFFFF;
    wait_cyc(4);
    expect_eq("R7 outputs quiet", {15'd0, irq_pull_en}, 16'd0);
    wr(3'd6, 8'hFF);
    wait_cyc(2);
    expect_eq("R10 out-to-in irq", {15'd0, irq_pull_en}, 16'd1);

    // R8 per-port clearing
    wr(3'd7, 8'hFF);
    wait_cyc(2);
    rd(3'd1, v);
    wait_cyc(2);
    expect_eq("R8 port1 read keeps port0", {15'd0, irq_pull_en}, 16'd1);
    rd(3'd0, v);
    wait_cyc(2);
    expect_eq("R8 port0 read clears", {15'd0, irq_pull_en}, 16'd0);
    pin_in[3] = 1'b0;
    wait_cyc(4);
    rd(3'd1, v);
    wait_cyc(2);
    expect_eq("R8 port1 read leaves port0 pending", {15'd0, irq_pull_en}, 16'd1);
    rd(3'd0, v);
    expect_eq("R8 snapshot value read", {8'd0, v}, 16'h00F7);
    wait_cyc(2);
    expect_eq("R8 cleared after port0 read", {15'd0, irq_pull_en}, 16'd0);

    // R11 latency through synchronizer and interrupt register
    pin_in[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    expect_eq("R11 not yet after two edges", {15'd0, irq_pull_en}, 16'd0);
    @(posedge clk); @(negedge clk);
    expect_eq("R11 raised after three edges", {15'd0, irq_pull_en}, 16'd1);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule